// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an internal core to an external byte-wide data memory over a shared address/data bus. The core issues one read or one write at a time. Each request carries a 24-bit address and, for writes, one data byte. The controller sends the address out and latches it with a single ALE pulse. It then runs a read or write strobe and, for reads, returns the byte with a one-cycle completion pulse.

Two ports carry the bus traffic. The low port is bidirectional in effect. It carries the address low byte during ALE and afterwards carries data: written by the controller on writes, released to the memory on reads. The high port is time-multiplexed. While ALE is high it carries the page byte (address bits 23:16), and after ALE falls it carries the high byte (bits 15:8). A second external latch on the high port therefore captures the page and extends the address space to 16 MB. A board without that latch sees only the high byte during the strobe, so the bus then behaves as an ordinary 64 kB interface.

Every access follows the same sequence, and its length depends only on the strobe width parameter. The sequence is: one ALE cycle, one hold cycle, a strobe of `STRB_CYC` cycles, and one recovery cycle. While an access is in flight, new requests are stalled.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset: `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `bus_lo_oe`=0, `rsp_done`=0.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle `ale` is 1 for exactly one cycle. In that cycle `bus_lo_oe`=1, `bus_lo_out`=addr[7:0] and `bus_hi`=addr[23:16].
- R3: From the cycle after ALE up to and including the recovery cycle, `bus_hi` carries addr[15:8].
- R4: After ALE there is one hold cycle with both strobes high. Then the strobe is low for exactly `STRB_CYC` consecutive cycles: `wr_n` when `req_write`=1, `rd_n` when `req_write`=0. One recovery cycle with both strobes high follows.
- R5: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is 1.
- R6: On a write, `bus_lo_oe`=1 and `bus_lo_out` equals the write data from the hold cycle through the recovery cycle. This covers the cycle before `wr_n` falls and the cycle after it rises.
- R7: On a read, `bus_lo_oe`=0 from the hold cycle through the recovery cycle. `rsp_rdata` takes the value on `bus_lo_in` during the last cycle in which `rd_n` is low.
- R8: `rsp_done` is a one-cycle pulse in the recovery cycle, `STRB_CYC`+3 cycles after the accepting edge. On a read, `rsp_rdata` holds the read byte from that cycle until the next read.
- R9: `req_ready` is 0 from the accepting edge until after the recovery cycle. A request held during that time is not taken early: its ALE comes exactly two cycles after `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Page, high and low address bytes |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request taken this edge |
| rsp_done | output | 1 | Access completion pulse |
| rsp_rdata | output | 8 | Read data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_lo_out | output | 8 | Low port drive value (address low / data) |
| bus_lo_oe | output | 1 | Low port output enable |
| bus_lo_in | input | 8 | Low port value from memory |
| bus_hi | output | 8 | High port (page, then high byte) |

## Verification
The collision that matters is completion and a fresh request arriving together: `rsp_done` rises while the core already holds the next request valid. The bench provokes this by keeping `req_valid` high with a new address straight through the previous access. It then requires that no ALE appears before `rsp_done`, that `req_ready` returns one cycle later, and that the new ALE carries the new address exactly two cycles after the pulse. A swept set of pages, high bytes and directions checks the latched bytes and the data against an arithmetic memory model in the bench.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ALE  = 3'd1,
        ST_HOLD = 3'd2,
        ST_STRB = 3'd3,
        ST_RECV = 3'd4
    } xm_state_e;

    typedef struct packed {
        logic              wr;
        logic [BYTE_W-1:0] page;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] wdata;
    } xm_req_t;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              oe;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } xm_bus_t;

    function automatic xm_req_t pack_req(input logic wr,
                                         input logic [ADDR_W-1:0] addr,
                                         input logic [BYTE_W-1:0] wdata);
        xm_req_t r;
        r.wr    = wr;
        r.page  = addr[3*BYTE_W-1:2*BYTE_W];
        r.hi    = addr[2*BYTE_W-1:BYTE_W];
        r.lo    = addr[BYTE_W-1:0];
        r.wdata = wdata;
        return r;
    endfunction

    function automatic xm_bus_t bus_idle();
        xm_bus_t b;
        b.ale  = 1'b0;
        b.rd_n = 1'b1;
        b.wr_n = 1'b1;
        b.oe   = 1'b0;
        b.lo   = '0;
        b.hi   = '0;
        return b;
    endfunction

endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int STRB_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  xm_req_t   req_in,
    output logic      req_ready,
    output xm_state_e state,
    output xm_req_t   cur,
    output logic      strb_last,
    output logic      done
);
    localparam int CW = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(STRB_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur   <= req_in;
                    state <= ST_ALE;
                end
                ST_ALE:  state <= ST_HOLD;
                ST_HOLD: begin
                    cnt   <= CNT_INIT;
                    state <= ST_STRB;
                end
                ST_STRB: begin
                    if (cnt == '0) state <= ST_RECV;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_RECV: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_RECV);
    assign strb_last = (state == ST_STRB) && (cnt == '0);

    // strobe window length, measured by an independent counter
    logic [CW:0] strb_seen;
    always_ff @(posedge clk) begin
        if (rst)                    strb_seen <= '0;
        else if (state == ST_STRB)  strb_seen <= strb_seen + 1'b1;
        else                        strb_seen <= '0;
    end

    assert_accept_starts_ale_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (state == ST_ALE));
    assert_strobe_len_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV) |-> (strb_seen == (CW+1)'(STRB_CYC)));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    assert_busy_holds_req_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && state != ST_IDLE) |=> $stable(cur));

endmodule

// File: rtl/xmem_drive.sv
module xmem_drive
    import xmem_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xm_state_e state,
    input  xm_req_t   cur,
    output xm_bus_t   bus
);
    always_comb begin
        bus = bus_idle();
        case (state)
            ST_ALE: begin
                bus.ale = 1'b1;
                bus.oe  = 1'b1;
                bus.lo  = cur.lo;
                bus.hi  = cur.page;
            end
            ST_HOLD, ST_RECV: begin
                bus.hi = cur.hi;
                bus.oe = cur.wr;
                bus.lo = cur.wr ? cur.wdata : '0;
            end
            ST_STRB: begin
                bus.hi   = cur.hi;
                bus.oe   = cur.wr;
                bus.lo   = cur.wr ? cur.wdata : '0;
                bus.rd_n = cur.wr;
                bus.wr_n = !cur.wr;
            end
            default: bus = bus_idle();
        endcase
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!bus.rd_n && !bus.wr_n));
    assert_no_strobe_in_ale_R5: assert property (@(posedge clk) disable iff (rst)
        bus.ale |-> (bus.rd_n && bus.wr_n));
    assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        bus.ale |=> !bus.ale);
    assert_read_released_R7: assert property (@(posedge clk) disable iff (rst)
        !bus.rd_n |-> !bus.oe);
    assert_wdata_before_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus.wr_n) |-> ($past(bus.oe) && bus.oe));
    assert_wdata_after_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus.wr_n) |-> (bus.oe && $stable(bus.lo)));

endmodule

// File: rtl/xmem_capture.sv
module xmem_capture
    import xmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_last,
    input  logic              is_write,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)                        rdata <= '0;
        else if (strb_last && !is_write) rdata <= bus_in;
    end

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(strb_last) |-> $stable(rdata));

endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int STRB_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        req_ready,
    output logic        rsp_done,
    output logic [7:0]  rsp_rdata,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  bus_lo_out,
    output logic        bus_lo_oe,
    input  logic [7:0]  bus_lo_in,
    output logic [7:0]  bus_hi
);
    xm_state_e state;
    xm_req_t   cur;
    xm_req_t   req_in;
    xm_bus_t   bus;
    logic      strb_last;

    assign req_in = pack_req(req_write, req_addr, req_wdata);

    xmem_seq #(.STRB_CYC(STRB_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .state     (state),
        .cur       (cur),
        .strb_last (strb_last),
        .done      (rsp_done)
    );

    xmem_drive u_drive (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .cur   (cur),
        .bus   (bus)
    );

    xmem_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .strb_last (strb_last),
        .is_write  (cur.wr),
        .bus_in    (bus_lo_in),
        .rdata     (rsp_rdata)
    );

    assign ale        = bus.ale;
    assign rd_n       = bus.rd_n;
    assign wr_n       = bus.wr_n;
    assign bus_lo_out = bus.lo;
    assign bus_lo_oe  = bus.oe;
    assign bus_hi     = bus.hi;

    assert_hi_after_ale_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (bus_hi == cur.hi));

endmodule

// File: tb/sim_xmem_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_bus_ctrl;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_done, ale, rd_n, wr_n, bus_lo_oe;
    logic [7:0] rsp_rdata, bus_lo_out, bus_hi, bus_lo_in;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] m_lo = '0, m_pg = '0, m_hi = '0, m_wd = '0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [7:0] pg, hi, lo);
        return (pg * 8'd3) ^ hi ^ (lo + 8'h5A);
    endfunction

    assign bus_lo_in = !rd_n ? mem_val(m_pg, bus_hi, m_lo) : 8'hC3;

    xmem_bus_ctrl #(.STRB_CYC(N)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe),
        .bus_lo_in(bus_lo_in), .bus_hi(bus_hi)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus monitor: external latch model and protocol checks
    int strb_run = 0;
    logic prev_strb = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (ale) begin
                m_lo = bus_lo_out;
                m_pg = bus_hi;
                chk(bus_lo_oe == 1'b1, "R2 oe during ALE", bus_lo_oe, 1);
            end
            if (!rd_n && !wr_n) chk(1'b0, "R5 both strobes low", 0, 1);
            if (ale && (!rd_n || !wr_n)) chk(1'b0, "R5 strobe during ALE", 0, 1);
            if (!rd_n) chk(bus_lo_oe == 1'b0, "R7 oe released in read", bus_lo_oe, 0);
            if (!wr_n) begin
                m_wd = bus_lo_out;
                chk(bus_lo_oe == 1'b1, "R6 oe during write strobe", bus_lo_oe, 1);
            end
            if (!rd_n || !wr_n) begin
                m_hi = bus_hi;
                strb_run++;
            end else begin
                if (prev_strb) chk(strb_run == N, "R4 strobe length", strb_run, N);
                strb_run = 0;
            end
            prev_strb = !rd_n || !wr_n;
        end
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // one access with full per-phase checking; called at a negedge
    task automatic access(input logic wr, input logic [23:0] a, input logic [7:0] d);
        int lat;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);                       // ALE cycle
        req_valid = 1'b0;
        chk(ale == 1'b1, "R2 ALE after accept", ale, 1);
        chk(bus_lo_out == a[7:0], "R2 low byte on low port", bus_lo_out, a[7:0]);
        chk(bus_hi == a[23:16], "R2 page on high port", bus_hi, a[23:16]);
        lat = 1;
        @(negedge clk);                       // hold cycle
        lat++;
        chk(!ale && rd_n && wr_n, "R4 hold cycle strobes high", {ale, rd_n, wr_n}, 3'b011);
        chk(bus_hi == a[15:8], "R3 high byte after ALE", bus_hi, a[15:8]);
        if (wr) chk(bus_lo_oe && bus_lo_out == d, "R6 data in hold", bus_lo_out, d);
        else    chk(!bus_lo_oe, "R7 released in hold", bus_lo_oe, 0);
        while (!rsp_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == N + 3, "R8 done latency", lat, N + 3);
        chk(rd_n && wr_n, "R4 recovery strobes high", {rd_n, wr_n}, 2'b11);
        chk(bus_hi == a[15:8], "R3 high byte in recovery", bus_hi, a[15:8]);
        chk(!req_ready, "R9 busy in recovery", req_ready, 0);
        chk(m_hi == a[15:8], "R3 high byte at strobe", m_hi, a[15:8]);
        if (wr) begin
            chk(bus_lo_oe && bus_lo_out == d, "R6 data after WR rise", bus_lo_out, d);
            chk(m_wd == d, "R6 written byte", m_wd, d);
        end else begin
            chk(!bus_lo_oe, "R7 released in recovery", bus_lo_oe, 0);
            chk(rsp_rdata == mem_val(a[23:16], a[15:8], a[7:0]), "R7 read data",
                rsp_rdata, mem_val(a[23:16], a[15:8], a[7:0]));
        end
        @(negedge clk);
        chk(!rsp_done && req_ready, "R8 done single pulse", {rsp_done, req_ready}, 2'b01);
    endtask

    initial begin
        logic [7:0] held;
        logic [7:0] hb [3];
        int k;
        hb[0] = 8'h00; hb[1] = 8'h5A; hb[2] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !ale && rd_n && wr_n && !bus_lo_oe && !rsp_done,
            "R1 reset state", {req_ready, ale, rd_n, wr_n, bus_lo_oe, rsp_done}, 6'b101100);

        for (int p = 0; p < 8; p++)
            for (int h = 0; h < 3; h++) begin
                logic [23:0] a;
                a = {8'(p * 37), hb[h], 8'(p * 17 + h * 5)};
                access(1'b1, a, 8'(p * 11 + h));
                access(1'b0, a, 8'h00);
            end

        // R8: read data held across a following write
        access(1'b0, 24'h12_34_56, 8'h00);
        held = rsp_rdata;
        access(1'b1, 24'h00_00_01, 8'hA5);
        chk(rsp_rdata == held, "R8 rdata held over write", rsp_rdata, held);

        // R9: next request held valid across completion
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'hAB_CD_EF;
        @(negedge clk);                       // accepted, ALE
        req_addr = 24'h7E_01_02;              // next request waits
        k = 0;
        while (!rsp_done && k < 40) begin
            @(negedge clk);
            k++;
            if (!rsp_done) chk(!ale && !req_ready, "R9 stalled while busy", {ale, req_ready}, 0);
        end
        chk(rsp_rdata == mem_val(8'hAB, 8'hCD, 8'hEF), "R7 read before stall",
            rsp_rdata, mem_val(8'hAB, 8'hCD, 8'hEF));
        @(negedge clk);
        chk(req_ready && !ale, "R9 ready one cycle after done", {req_ready, ale}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale && bus_hi == 8'h7E && bus_lo_out == 8'h02, "R9 new ALE two after done",
            {bus_hi, bus_lo_out}, 16'h7E02);
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata == mem_val(8'h7E, 8'h01, 8'h02), "R7 stalled read data",
            rsp_rdata, mem_val(8'h7E, 8'h01, 8'h02));
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule